// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the device side of a byte-wide parallel flash with a 16-bit address space split into sixteen 4 KB pages. It watches the write cycles that the bus front end hands it as address/data pairs, and it recognises the multi-write unlock sequences. From them it issues requests to an external array engine: program one byte, erase one page or erase the whole chip. It also handles some sequences on its own: entering and leaving identification mode and arming a lock on the top or bottom 8 KB boot region. The array storage and the program/erase timing sit outside. They are reached through a request channel with a valid/ready handshake and a one-cycle completion pulse.

Reads are also routed through the block. In normal mode a read returns the byte that the array presents for the read address. In identification mode a read returns the identifier codes or the lock status. While an operation is in flight a read returns a status byte with a polling bit and a toggling bit. The write and read strobes are never back-pressured: every strobe is consumed in the cycle it is seen, and the read response appears exactly one cycle later. Only the request channel to the array engine stalls. It holds its payload until the engine takes it, and the engine may hold ready low for as long as it needs.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in normal read mode, outside identification mode, with both lock flags clear, `busy` low and `op_valid` low. Every `rd_valid` produces `rsp_valid` one cycle later. In normal mode `rsp_data` is the `arr_rdata` value sampled together with `rd_valid`.
- R2: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by any address/data write, raise `op_valid` in the cycle after that fourth write. The request then carries `op_kind`=0, the written address and the written data, with `op_skip`=0.
- R3: The erase prefix is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh. The prefix followed by 10h@5555h issues `op_kind`=2. `op_addr` is the address of that last write, `op_data`=00h, and `op_skip` = {top lock, bottom lock}.
- R4: The erase prefix followed by 50h written to any address issues `op_kind`=1. `op_addr` is that address (bits 15:12 select the page) and `op_data`=00h.
- R5: The payload (`op_kind`, `op_addr`, `op_data`, `op_skip`) is held stable until `op_ready` is seen high. `busy` is high from the cycle after the final command write until the cycle after `op_done` is sampled, and then normal reads resume.
- R6: Writes that arrive while `busy` is high are ignored. They neither advance nor break a sequence.
- R7: A write whose address or data does not match the expected step returns the sequencer to its first step, and that write is consumed. Identification mode is kept, except for the F0h exit rules of R10.
- R8: Unlock followed by 90h@5555h enters identification mode. A read there whose low address byte is 00h returns the manufacturer code, and one whose low byte is 01h returns the device code. Each code is a 7-bit parameter with an odd-parity bit added as bit 7 (defaults C2h and 26h). Any other address, apart from those in R9, returns 00h.
- R9: In identification mode a read at 0002h returns the bottom lock flag on bit 0, and a read at FFF2h returns the top lock flag on bit 1. All other bits of these two reads are 0.
- R10: Identification mode is left by unlock followed by F0h@5555h, or by a single F0h write to any address when no sequence is in progress.
- R11: The erase prefix followed by 70h@5555h and one more write locks a boot region. The top region (E000h–FFFFh) is locked if that write goes to FFFFh, and the bottom region (0000h–1FFFh) if it goes to 0000h. Any other address locks nothing. No request is issued, and a lock flag clears only on reset.
- R12: A program, or a page erase, whose address lies in a locked region issues no request and leaves `busy` low. The same command outside the locked regions is still issued.
- R13: While `busy` is high a read returns {poll, toggle, 000000b}. During a program, poll is the inverse of bit 7 of the programmed data; during an erase, poll is 0. The toggle bit is 0 on the first status read after the final command write and inverts on each further status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe, one cycle per bus write, never stalled |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| rd_valid | input | 1 | Read strobe, never stalled |
| rd_addr | input | 16 | Read address |
| arr_rdata | input | 8 | Array byte for `rd_addr`, same cycle |
| rsp_valid | output | 1 | Read response valid, one cycle after `rd_valid` |
| rsp_data | output | 8 | Read response byte |
| op_valid | output | 1 | Request to the array engine pending |
| op_ready | input | 1 | Array engine accepts the request |
| op_kind | output | 2 | 0 program, 1 page erase, 2 chip erase |
| op_addr | output | 16 | Target address |
| op_data | output | 8 | Program data (00h for erases) |
| op_skip | output | 2 | Regions the chip erase must leave alone: bit 1 top, bit 0 bottom |
| op_done | input | 1 | One-cycle completion pulse from the array engine |
| busy | output | 1 | An operation is pending or running |

## Verification
The bench builds the block with its default parameters: 16 address bits, 4 page bits and a two-page boot region, so each locked region covers 8 KB. The identifier payloads are 42h and 26h, which produce one code with a computed parity bit of 1 and one with a parity bit of 0. With these values both boot regions sit at the very ends of the address range. A handful of addresses, such as F000h, E123h, D000h, 1FFFh and 2000h, are enough to probe both sides of each region boundary. The array engine in the bench answers with short and varied ready and done latencies. These expose the held request payload and the window in which status reads and ignored writes fall.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_PAGE = 2'd1,
    OP_CHIP = 2'd2
  } op_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_U1,
    ST_U2,
    ST_PROG,
    ST_E80,
    ST_EU1,
    ST_EU2,
    ST_LOCK,
    ST_ISSUE,
    ST_BUSY
  } seq_st_e;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_PAGE  = 8'h50;
  localparam logic [7:0] CMD_LOCK  = 8'h70;
  localparam logic [7:0] CMD_IDIN  = 8'h90;
  localparam logic [7:0] CMD_IDOUT = 8'hF0;

endpackage

// File: rtl/fsq_lock.sv
module fsq_lock #(
  parameter int BOOT_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           set_req,
  input  logic [BOOT_BITS-1:0] chk_top,
  output logic [1:0]           lock_q,
  output logic                 chk_hit
);

  logic [1:0] match;

  // region 0 is the bottom block, region 1 the top block
  for (genvar g = 0; g < 2; g++) begin : g_region
    logic flag_q;

    if (g == 0) begin : g_bot
      assign match[g] = (chk_top == '0);
    end else begin : g_top
      assign match[g] = (chk_top == '1);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else if (set_req[g]) flag_q <= 1'b1;
    end

    assign lock_q[g] = flag_q;

    // R11
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(flag_q));
  end

  assign chk_hit = |(lock_q & match);

endmodule

// File: rtl/fsq_decoder.sv
module fsq_decoder
  import fsq_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 16'h5555,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 16'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              prot_hit,
  input  logic [1:0]        lock_q,
  input  logic              op_ready,
  input  logic              op_done,
  output logic              op_valid,
  output op_kind_e          op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic [1:0]        op_skip,
  output logic              busy,
  output logic              id_mode,
  output logic              poll_bit,
  output logic              op_start,
  output logic [1:0]        set_req
);

  seq_st_e           st_q, st_d;
  logic              id_q, id_d;
  op_kind_e          kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic [1:0]        skip_q, skip_d;

  logic at_a, at_b;
  assign at_a = (wr_addr == UNLOCK_A);
  assign at_b = (wr_addr == UNLOCK_B);

  always_comb begin
    st_d     = st_q;
    id_d     = id_q;
    kind_d   = kind_q;
    addr_d   = addr_q;
    data_d   = data_q;
    skip_d   = skip_q;
    op_start = 1'b0;
    set_req  = 2'b00;
    case (st_q)
      ST_ISSUE: if (op_ready) st_d = ST_BUSY;
      ST_BUSY:  if (op_done)  st_d = ST_IDLE;
      default: begin
        if (wr_valid) begin
          st_d = ST_IDLE;
          case (st_q)
            ST_IDLE: begin
              if (at_a && wr_data == CMD_KEY1) st_d = ST_U1;
              else if (wr_data == CMD_IDOUT) id_d = 1'b0;
            end
            ST_U1: if (at_b && wr_data == CMD_KEY2) st_d = ST_U2;
            ST_U2: begin
              if (at_a) begin
                case (wr_data)
                  CMD_PROG:  st_d = ST_PROG;
                  CMD_ERASE: st_d = ST_E80;
                  CMD_IDIN:  id_d = 1'b1;
                  CMD_IDOUT: id_d = 1'b0;
                  default:   st_d = ST_IDLE;
                endcase
              end
            end
            ST_PROG: begin
              if (!prot_hit) begin
                st_d     = ST_ISSUE;
                kind_d   = OP_PROG;
                addr_d   = wr_addr;
                data_d   = wr_data;
                skip_d   = 2'b00;
                op_start = 1'b1;
              end
            end
            ST_E80: if (at_a && wr_data == CMD_KEY1) st_d = ST_EU1;
            ST_EU1: if (at_b && wr_data == CMD_KEY2) st_d = ST_EU2;
            ST_EU2: begin
              if (at_a && wr_data == CMD_CHIP) begin
                st_d     = ST_ISSUE;
                kind_d   = OP_CHIP;
                addr_d   = wr_addr;
                data_d   = 8'h00;
                skip_d   = lock_q;
                op_start = 1'b1;
              end else if (wr_data == CMD_PAGE) begin
                if (!prot_hit) begin
                  st_d     = ST_ISSUE;
                  kind_d   = OP_PAGE;
                  addr_d   = wr_addr;
                  data_d   = 8'h00;
                  skip_d   = 2'b00;
                  op_start = 1'b1;
                end
              end else if (at_a && wr_data == CMD_LOCK) begin
                st_d = ST_LOCK;
              end
            end
            ST_LOCK: begin
              set_req[1] = &wr_addr;
              set_req[0] = ~|wr_addr;
            end
            default: st_d = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      id_q   <= 1'b0;
      kind_q <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      skip_q <= '0;
    end else begin
      st_q   <= st_d;
      id_q   <= id_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      data_q <= data_d;
      skip_q <= skip_d;
    end
  end

  assign op_valid = (st_q == ST_ISSUE);
  assign busy     = (st_q == ST_ISSUE) || (st_q == ST_BUSY);
  assign op_kind  = kind_q;
  assign op_addr  = addr_q;
  assign op_data  = data_q;
  assign op_skip  = skip_q;
  assign id_mode  = id_q;
  assign poll_bit = (kind_q == OP_PROG) ? ~data_q[7] : 1'b0;

  // R5
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_addr) && $stable(op_data)
                                 && $stable(op_kind) && $stable(op_skip)));

  // R2
  op_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> $past(wr_valid));

  // R6
  op_not_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> !$past(busy));

endmodule

// File: rtl/fsq_readback.sv
module fsq_readback #(
  parameter int             ADDR_W  = 16,
  parameter logic [6:0]     MFR_ID7 = 7'h42,
  parameter logic [6:0]     DEV_ID7 = 7'h26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  input  logic              busy,
  input  logic              id_mode,
  input  logic [1:0]        lock_q,
  input  logic              poll_bit,
  input  logic              op_start,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data
);

  localparam logic [7:0]        MFR_CODE = {~^MFR_ID7, MFR_ID7};
  localparam logic [7:0]        DEV_CODE = {~^DEV_ID7, DEV_ID7};
  localparam logic [ADDR_W-1:0] BOT_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] TOP_STAT = {{(ADDR_W-8){1'b1}}, 8'hF2};

  logic [7:0] id_byte;
  logic       tog_q;

  always_comb begin
    if (rd_addr == BOT_STAT)          id_byte = {7'b0, lock_q[0]};
    else if (rd_addr == TOP_STAT)     id_byte = {6'b0, lock_q[1], 1'b0};
    else if (rd_addr[7:0] == 8'h00)   id_byte = MFR_CODE;
    else if (rd_addr[7:0] == 8'h01)   id_byte = DEV_CODE;
    else                              id_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
      tog_q     <= 1'b0;
    end else begin
      rsp_valid <= rd_valid;
      if (op_start) tog_q <= 1'b0;
      if (rd_valid) begin
        if (busy) begin
          rsp_data <= {poll_bit, tog_q, 6'b0};
          tog_q    <= ~tog_q;
        end else if (id_mode) begin
          rsp_data <= id_byte;
        end else begin
          rsp_data <= arr_rdata;
        end
      end
    end
  end

  // R13
  status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && busy) |=> (rsp_valid && rsp_data[5:0] == 6'b0));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fsq_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         PAGE_W     = 4,
  parameter int         BOOT_PAGES = 2,
  parameter logic [6:0] MFR_ID7    = 7'h42,
  parameter logic [6:0] DEV_ID7    = 7'h26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic [1:0]        op_skip,
  input  logic              op_done,
  output logic              busy
);

  localparam int BOOT_BITS = PAGE_W - $clog2(BOOT_PAGES);

  logic       prot_hit;
  logic [1:0] lock_q;
  logic [1:0] set_req;
  logic       id_mode;
  logic       poll_bit;
  logic       op_start;
  op_kind_e   kind_e;
  logic [BOOT_BITS-1:0] wr_region;

  assign wr_region = wr_addr[ADDR_W-1 -: BOOT_BITS];
  assign op_kind   = kind_e;

  fsq_lock #(.BOOT_BITS(BOOT_BITS)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (set_req),
    .chk_top (wr_region),
    .lock_q  (lock_q),
    .chk_hit (prot_hit)
  );

  fsq_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .prot_hit (prot_hit),
    .lock_q   (lock_q),
    .op_ready (op_ready),
    .op_done  (op_done),
    .op_valid (op_valid),
    .op_kind  (kind_e),
    .op_addr  (op_addr),
    .op_data  (op_data),
    .op_skip  (op_skip),
    .busy     (busy),
    .id_mode  (id_mode),
    .poll_bit (poll_bit),
    .op_start (op_start),
    .set_req  (set_req)
  );

  fsq_readback #(.ADDR_W(ADDR_W), .MFR_ID7(MFR_ID7), .DEV_ID7(DEV_ID7)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .arr_rdata (arr_rdata),
    .busy      (busy),
    .id_mode   (id_mode),
    .lock_q    (lock_q),
    .poll_bit  (poll_bit),
    .op_start  (op_start),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // R12
  prot_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind != 2'd2) |->
      !((lock_q[1] && (&op_addr[ADDR_W-1 -: BOOT_BITS])) ||
        (lock_q[0] && (~|op_addr[ADDR_W-1 -: BOOT_BITS]))));

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        rd_valid;
  logic [15:0] rd_addr;
  logic [7:0]  arr_rdata;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        op_valid;
  logic        op_ready;
  logic [1:0]  op_kind;
  logic [15:0] op_addr;
  logic [7:0]  op_data;
  logic [1:0]  op_skip;
  logic        op_done;
  logic        busy;

  always #2 clk = ~clk;

  assign arr_rdata = rd_addr[7:0] ^ rd_addr[15:8] ^ 8'h5A;

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .op_skip(op_skip),
    .op_done(op_done), .busy(busy)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  int    ready_lat = 3;
  int    done_lat  = 12;
  bit    finished  = 0;

  task automatic check_eq(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_step, m_phase, m_tog, m_kind;
  bit         m_id, m_lbot, m_ltop, m_rsp_v;
  logic [15:0] m_addr;
  logic [7:0]  m_data, m_rsp_d;
  logic [1:0]  m_skip;

  function automatic bit in_locked(logic [15:0] a);
    return (m_lbot && a[15:13] == 3'd0) || (m_ltop && a[15:13] == 3'd7);
  endfunction

  function automatic logic [7:0] id_value(logic [15:0] a);
    if (a == 16'h0002) return {7'b0, m_lbot};
    if (a == 16'hFFF2) return {6'b0, m_ltop, 1'b0};
    if (a[7:0] == 8'h00) return 8'hC2;
    if (a[7:0] == 8'h01) return 8'h26;
    return 8'h00;
  endfunction

  task automatic m_issue(int k, logic [15:0] a, logic [7:0] d, logic [1:0] s);
    m_kind = k; m_addr = a; m_data = d; m_skip = s; m_phase = 1; m_tog = 0;
  endtask

  task automatic m_write(logic [15:0] a, logic [7:0] d);
    int nxt;
    nxt = 0;
    case (m_step)
      0: if (a == 16'h5555 && d == 8'hAA) nxt = 1; else if (d == 8'hF0) m_id = 0;
      1: if (a == 16'h2AAA && d == 8'h55) nxt = 2;
      2: if (a == 16'h5555) begin
           if (d == 8'hA0) nxt = 3;
           else if (d == 8'h80) nxt = 4;
           else if (d == 8'h90) m_id = 1;
           else if (d == 8'hF0) m_id = 0;
         end
      3: if (!in_locked(a)) m_issue(0, a, d, 2'b00);
      4: if (a == 16'h5555 && d == 8'hAA) nxt = 5;
      5: if (a == 16'h2AAA && d == 8'h55) nxt = 6;
      6: if (a == 16'h5555 && d == 8'h10) m_issue(2, a, 8'h00, {m_ltop, m_lbot});
         else if (d == 8'h50) begin if (!in_locked(a)) m_issue(1, a, 8'h00, 2'b00); end
         else if (a == 16'h5555 && d == 8'h70) nxt = 7;
      7: begin if (a == 16'hFFFF) m_ltop = 1; if (a == 16'h0000) m_lbot = 1; end
      default: nxt = 0;
    endcase
    m_step = nxt;
  endtask

  always @(posedge clk) begin
    int old_phase;
    if (!rst_n) begin
      m_step = 0; m_phase = 0; m_tog = 0; m_kind = 0; m_id = 0; m_lbot = 0; m_ltop = 0;
      m_rsp_v = 0; m_addr = 0; m_data = 0; m_skip = 0; m_rsp_d = 0;
    end else begin
      old_phase = m_phase;
      m_rsp_v = rd_valid;
      if (rd_valid) begin
        if (old_phase != 0) begin
          m_rsp_d = {(m_kind == 0) ? ~m_data[7] : 1'b0, m_tog[0], 6'b0};
          m_tog = m_tog ^ 1;
        end else if (m_id) m_rsp_d = id_value(rd_addr);
        else m_rsp_d = arr_rdata;
      end
      if (old_phase == 1 && op_ready) m_phase = 2;
      else if (old_phase == 2 && op_done) m_phase = 0;
      if (old_phase == 0 && wr_valid) m_write(wr_addr, wr_data);
    end
  end

  // compare on every clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check_eq(cur_req, "busy", busy, m_phase != 0);
      check_eq(cur_req, "op_valid", op_valid, m_phase == 1);
      if (m_phase == 1) begin
        check_eq(cur_req, "op_kind", op_kind, m_kind);
        check_eq(cur_req, "op_addr", op_addr, m_addr);
        check_eq(cur_req, "op_data", op_data, m_data);
        check_eq(cur_req, "op_skip", op_skip, m_skip);
      end
      check_eq(cur_req, "rsp_valid", rsp_valid, m_rsp_v);
      if (m_rsp_v) check_eq(cur_req, "rsp_data", rsp_data, m_rsp_d);
    end
  end

  // ---------------- array engine responder ----------------
  initial begin
    int rs, cnt;
    rs = 0; cnt = 0; op_ready = 0; op_done = 0;
    forever begin
      @(negedge clk);
      op_ready = 0; op_done = 0;
      if (!rst_n) begin rs = 0; cnt = 0; end
      else if (rs == 0) begin
        if (op_valid) begin
          if (cnt >= ready_lat) begin op_ready = 1; rs = 1; cnt = 0; end
          else cnt++;
        end
      end else begin
        cnt++;
        if (cnt >= done_lat) begin op_done = 1; rs = 0; cnt = 0; end
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic do_read(logic [15:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    rd_valid = 1; rd_addr = a;
    @(negedge clk);
    rd_valid = 0;
    check_eq(req, "read valid", rsp_valid, 1);
    check_eq(req, "read data", rsp_data, exp);
  endtask

  task automatic unlock();
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
  endtask

  task automatic eprefix();
    unlock();
    wr(16'h5555, 8'h80);
    unlock();
  endtask

  task automatic expect_op(string req, int k, logic [15:0] a, logic [7:0] d, logic [1:0] s);
    check_eq(req, "op_valid", op_valid, 1);
    check_eq(req, "op_kind", op_kind, k);
    check_eq(req, "op_addr", op_addr, a);
    check_eq(req, "op_data", op_data, d);
    check_eq(req, "op_skip", op_skip, s);
  endtask

  task automatic expect_none(string req);
    check_eq(req, "no op_valid", op_valid, 0);
    check_eq(req, "no busy", busy, 0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    @(negedge clk);
    check_eq(cur_req, "idle after done", busy, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- directed sequence ----------------
  initial begin
    rst_n = 0; wr_valid = 0; wr_addr = 0; wr_data = 0; rd_valid = 0; rd_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R1", "reset busy", busy, 0);
    check_eq("R1", "reset op_valid", op_valid, 0);
    check_eq("R1", "reset rsp_valid", rsp_valid, 0);
    rst_n = 1;
    cur_req = "R1";
    do_read(16'h1234, 8'h7C, "R1");

    cur_req = "R2";
    unlock(); wr(16'h5555, 8'hA0); wr(16'h1234, 8'h3C);
    expect_op("R2", 0, 16'h1234, 8'h3C, 2'b00);
    cur_req = "R13";
    do_read(16'h0100, 8'h80, "R13");
    do_read(16'h0100, 8'hC0, "R13");
    cur_req = "R5";
    check_eq("R5", "busy during op", busy, 1);
    wait_idle();
    do_read(16'h1234, 8'h7C, "R5");

    cur_req = "R6";
    unlock(); wr(16'h5555, 8'hA0); wr(16'h2000, 8'h55);
    expect_op("R6", 0, 16'h2000, 8'h55, 2'b00);
    unlock();
    wait_idle();
    wr(16'h5555, 8'hA0); expect_none("R6");
    wr(16'h4444, 8'h11); expect_none("R6");

    cur_req = "R7";
    unlock(); wr(16'h5555, 8'h33); wr(16'h5555, 8'hA0); wr(16'h5000, 8'h22);
    expect_none("R7");
    wr(16'h5555, 8'hAA); wr(16'h1111, 8'h55); wr(16'h5555, 8'hA0); wr(16'h6000, 8'h01);
    expect_none("R7");

    cur_req = "R4";
    ready_lat = 0;
    eprefix(); wr(16'h7ABC, 8'h50);
    expect_op("R4", 1, 16'h7ABC, 8'h00, 2'b00);
    do_read(16'h7000, 8'h00, "R13");
    do_read(16'h7000, 8'h40, "R13");
    wait_idle();

    cur_req = "R3";
    ready_lat = 2; done_lat = 5;
    eprefix(); wr(16'h5555, 8'h10);
    expect_op("R3", 2, 16'h5555, 8'h00, 2'b00);
    wait_idle();

    cur_req = "R8";
    unlock(); wr(16'h5555, 8'h90);
    do_read(16'h0000, 8'hC2, "R8");
    do_read(16'h3401, 8'h26, "R8");
    do_read(16'h0055, 8'h00, "R8");
    cur_req = "R9";
    do_read(16'h0002, 8'h00, "R9");
    do_read(16'hFFF2, 8'h00, "R9");

    cur_req = "R11";
    eprefix(); wr(16'h5555, 8'h70); wr(16'hFFFF, 8'h00);
    expect_none("R11");
    do_read(16'hFFF2, 8'h02, "R11");
    do_read(16'h0002, 8'h00, "R11");
    eprefix(); wr(16'h5555, 8'h70); wr(16'h1234, 8'h00);
    do_read(16'h0002, 8'h00, "R11");

    cur_req = "R10";
    wr(16'h0777, 8'hF0);
    do_read(16'h0000, 8'h5A, "R10");

    cur_req = "R12";
    ready_lat = 1;
    unlock(); wr(16'h5555, 8'hA0); wr(16'hF000, 8'h12); expect_none("R12");
    unlock(); wr(16'h5555, 8'hA0); wr(16'h8000, 8'h12);
    expect_op("R12", 0, 16'h8000, 8'h12, 2'b00);
    wait_idle();
    eprefix(); wr(16'hE123, 8'h50); expect_none("R12");
    eprefix(); wr(16'hD000, 8'h50);
    expect_op("R12", 1, 16'hD000, 8'h00, 2'b00);
    wait_idle();
    eprefix(); wr(16'h5555, 8'h10);
    expect_op("R3", 2, 16'h5555, 8'h00, 2'b10);
    wait_idle();

    cur_req = "R11";
    eprefix(); wr(16'h5555, 8'h70); wr(16'h0000, 8'h00);
    unlock(); wr(16'h5555, 8'h90);
    do_read(16'h0002, 8'h01, "R9");
    do_read(16'hFFF2, 8'h02, "R9");
    unlock(); wr(16'h5555, 8'hF0);
    do_read(16'h0000, 8'h5A, "R10");
    cur_req = "R12";
    unlock(); wr(16'h5555, 8'hA0); wr(16'h1FFF, 8'h00); expect_none("R12");
    eprefix(); wr(16'h1000, 8'h50); expect_none("R12");
    unlock(); wr(16'h5555, 8'hA0); wr(16'h2000, 8'h80);
    expect_op("R12", 0, 16'h2000, 8'h80, 2'b00);
    do_read(16'h2000, 8'h00, "R13");
    wait_idle();
    eprefix(); wr(16'h5555, 8'h10);
    expect_op("R3", 2, 16'h5555, 8'h00, 2'b11);
    wait_idle();

    cur_req = "R1";
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    check_eq("R1", "busy after reset", busy, 0);
    unlock(); wr(16'h5555, 8'h90);
    do_read(16'h0002, 8'h00, "R1");
    do_read(16'hFFF2, 8'h00, "R1");
    wr(16'h0000, 8'hF0);
    do_read(16'h0001, 8'h5B, "R1");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule